// File: doc/BRIEF.md
# Satellite Tuner Programming Word Generator

This block turns a requested L-band tuning frequency (in kHz) and a transmission symbol rate (in symbols per second) into the settings a satellite downconverter tuner needs. It produces four 21-bit programming words and one 10-bit filter-tune value. The words are a variable-attenuator word and a variable-gain word, both picked by symbol-rate class, a band-select word, and a synthesizer divider word. The divider word holds the charge-pump current code and the N/A prescaler counts for the selected band.

A controller applies the frequency, the symbol rate and an optional band override, then pulses `start_i`. The block captures the inputs and looks up the rate class and the band. It runs the prescaler division on an internal shift-subtract divider. When all five outputs are updated together, it pulses `done_o` for one cycle. The outputs keep their values until the next accepted request. A serializer placed after this block can then ship the words to the tuner.

Top module: `tuner_word_gen`

## Requirements
- R1: The symbol-rate classes and their outputs are:
  - class A, 1,000,000 to 4,999,999: attenuator word 0x100E07, gain word 0x0B01E0, filter tune 0x27F.
  - class B, 5,000,000 to 14,999,999: attenuator word 0x100E1F, gain word 0x0B01E0, filter tune 0x317.
  - class C, 15,000,000 to 45,000,000: attenuator word 0x100E3F, gain word 0x0A0180, filter tune 0x145.
- R2: A symbol rate outside every class produces the class A attenuator word, gain word and filter tune, and the request still completes with `done_o`.
- R3: With automatic selection, the frequency picks one of nine bands. The lower edges are 950000, 1075000, 1178000, 1296000, 1432000, 1576000, 1718000, 1856000 and 2036000 kHz. Each band ends one below the next band's lower edge, and the last band ends at 2150000. The band word is 0x040 for band 1 and 0x080 for band 2. For band k from 3 to 9 it is 0x200 | (1 << (k-3)).
- R4: With automatic selection, a frequency outside all nine bands selects band 1.
- R5: An override value of 1 to 9 on `band_force_i` forces that band whatever the frequency. Any other value (0, or 10 to 15) gives automatic selection.
- R6: The charge-pump code is 1 when the frequency is below the integer midpoint (lower+upper)/2 of the selected band's edges, and 2 otherwise.
- R7: The quotient q is floor(f × d × 10 / 20222), where d is 4 for bands 1 and 2 and 2 for bands 3 to 9. N is bits [13:5] of q and A is bits [4:0] of q.
- R8: When A is 0, N is incremented by one, wrapping in 9 bits.
- R9: The divider word is laid out as follows:
  - bits [20:16] = 5'b11111
  - bits [15:14] = charge-pump code
  - bits [13:5] = N
  - bits [4:0] = A
- R10: `busy_o` rises in the cycle after an accepted `start_i`. All outputs update together, and `done_o` is high for exactly one cycle as `busy_o` falls.
- R11: A `start_i` pulse while `busy_o` is high is ignored. It yields no extra `done_o` and does not change the result in progress.
- R12: After reset every output is zero. Between completions the five outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| freq_khz_i | input | 22 | Tuning frequency in kHz |
| sym_rate_i | input | 26 | Symbol rate in symbols per second |
| band_force_i | input | 4 | Band override: 1 to 9 force a band, other values mean automatic |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when outputs are updated |
| vca_word_o | output | 21 | Attenuator programming word |
| vga_word_o | output | 21 | Gain programming word |
| band_word_o | output | 21 | Band-select programming word |
| pll_word_o | output | 21 | Synthesizer divider word |
| filt_tune_o | output | 10 | Filter-tune control value |

## Verification
The hardest case to reach from the ports is a quotient whose low five bits are all zero, because only rare frequencies give it. The stimulus uses 2070733 kHz: times 20, this lands just above 2048 × 20222, so A is 0 and N is bumped. The bench also drives forced bands against frequencies far outside them, edge values of both bands and rate classes, and a second start during a running division. A reference model in the bench predicts every word, and a scoreboard matches results as they arrive.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

  localparam int WORD_W      = 21;
  localparam int FT_W        = 10;
  localparam int N_W         = 9;
  localparam int A_W         = 5;
  localparam int NUM_RANGES  = 3;
  localparam int NUM_BANDS   = 9;
  localparam int NUM_DIV4    = 2;
  localparam int IDX_W       = $clog2(NUM_BANDS);
  localparam int RIDX_W      = $clog2(NUM_RANGES);

  typedef logic [WORD_W-1:0] tword_t;

  localparam logic [31:0] RATE_LO [NUM_RANGES] = '{32'd1000000, 32'd5000000, 32'd15000000};
  localparam logic [31:0] RATE_HI [NUM_RANGES] = '{32'd4999999, 32'd14999999, 32'd45000000};
  localparam logic [8:0]  ATT_LOW [NUM_RANGES] = '{9'h007, 9'h01F, 9'h03F};
  localparam logic [8:0]  GAIN_MID[NUM_RANGES] = '{9'h180, 9'h180, 9'h100};
  localparam logic [8:0]  GAIN_LOW[NUM_RANGES] = '{9'h1E0, 9'h1E0, 9'h180};
  localparam logic [FT_W-1:0] FT_VAL[NUM_RANGES] = '{10'h27F, 10'h317, 10'h145};

  localparam logic [31:0] BAND_LO [NUM_BANDS] = '{
    32'd950000,  32'd1075000, 32'd1178000, 32'd1296000, 32'd1432000,
    32'd1576000, 32'd1718000, 32'd1856000, 32'd2036000};
  localparam logic [31:0] BAND_TOP = 32'd2150000;

  function automatic logic [31:0] band_hi(int i);
    logic [31:0] r;
    if (i >= NUM_BANDS - 1) r = BAND_TOP;
    else                    r = BAND_LO[i+1] - 32'd1;
    return r;
  endfunction

  function automatic logic [31:0] band_mid(int i);
    return (BAND_LO[i] + band_hi(i)) >> 1;
  endfunction

  function automatic tword_t band_code(int i);
    tword_t w;
    if (i == 0)             w = tword_t'(12'h040);
    else if (i < NUM_DIV4)  w = tword_t'(12'h080);
    else                    w = tword_t'(1 << 9) | tword_t'(1 << (i - NUM_DIV4));
    return w;
  endfunction

  function automatic tword_t att_code(int i);
    return {2'd2, 1'b0, 9'h007, ATT_LOW[i]};
  endfunction

  function automatic tword_t gain_code(int i);
    return {2'd1, 1'b0, GAIN_MID[i], GAIN_LOW[i]};
  endfunction

endpackage

// File: rtl/tuner_rate_sel.sv
module tuner_rate_sel
  import tuner_pkg::*;
#(
  parameter int RATE_W = 26
) (
  input  logic [RATE_W-1:0] rate_i,
  output tword_t            att_o,
  output tword_t            gain_o,
  output logic [FT_W-1:0]   ft_o
);

  logic [NUM_RANGES-1:0] hit;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    assign hit[g] = (32'(rate_i) >= RATE_LO[g]) && (32'(rate_i) <= RATE_HI[g]);
  end

  // Unmatched rates fall back to the first class.
  always_comb begin
    att_o  = att_code(0);
    gain_o = gain_code(0);
    ft_o   = FT_VAL[0];
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (hit[i]) begin
        att_o  = att_code(i);
        gain_o = gain_code(i);
        ft_o   = FT_VAL[i];
      end
    end
  end

endmodule

// File: rtl/tuner_band_sel.sv
module tuner_band_sel
  import tuner_pkg::*;
#(
  parameter int FREQ_W  = 22,
  parameter int FORCE_W = 4
) (
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic [FORCE_W-1:0] force_i,
  output tword_t             band_word_o,
  output logic               div4_o,
  output logic [1:0]         pump_o
);

  logic [NUM_BANDS-1:0] hit;
  logic [IDX_W-1:0]     auto_idx;
  logic [IDX_W-1:0]     idx;
  logic                 forced;
  logic [31:0]          mid;

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
    assign hit[g] = (32'(freq_i) >= BAND_LO[g]) && (32'(freq_i) <= band_hi(g));
  end

  // Out-of-band frequencies default to band index 0.
  always_comb begin
    auto_idx = '0;
    for (int i = 0; i < NUM_BANDS; i++) begin
      if (hit[i]) auto_idx = IDX_W'(i);
    end
  end

  assign forced = (32'(force_i) >= 32'd1) && (32'(force_i) <= 32'(NUM_BANDS));
  assign idx    = forced ? IDX_W'(force_i - FORCE_W'(1)) : auto_idx;

  always_comb begin
    band_word_o = band_code(0);
    div4_o      = 1'b1;
    mid         = band_mid(0);
    for (int i = 0; i < NUM_BANDS; i++) begin
      if (idx == IDX_W'(i)) begin
        band_word_o = band_code(i);
        div4_o      = (i < NUM_DIV4);
        mid         = band_mid(i);
      end
    end
  end

  assign pump_o = (32'(freq_i) < mid) ? 2'd1 : 2'd2;

endmodule

// File: rtl/tuner_seq_div.sv
module tuner_seq_div #(
  parameter int          NUM_W   = 28,
  parameter int          DEN_W   = 15,
  parameter int unsigned DIVISOR = 20222
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [DEN_W:0] DEN = (DEN_W+1)'(DIVISOR);

  logic [DEN_W-1:0] rem;
  logic [NUM_W-1:0] quo;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   trial;

  assign trial = {rem, quo[NUM_W-1]};
  assign quo_o = quo;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      quo    <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        rem    <= '0;
        quo    <= num_i;
        cnt    <= CNT_W'(NUM_W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (trial >= DEN) begin
          rem <= DEN_W'(trial - DEN);
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R7
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, rem} < DEN));

  // R7
  div_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

endmodule

// File: rtl/tuner_word_gen.sv
module tuner_word_gen
  import tuner_pkg::*;
#(
  parameter int FREQ_W  = 22,
  parameter int RATE_W  = 26,
  parameter int FORCE_W = 4,
  parameter int XTAL_HZ = 10111000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [FREQ_W-1:0]  freq_khz_i,
  input  logic [RATE_W-1:0]  sym_rate_i,
  input  logic [FORCE_W-1:0] band_force_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [20:0]        vca_word_o,
  output logic [20:0]        vga_word_o,
  output logic [20:0]        band_word_o,
  output logic [20:0]        pll_word_o,
  output logic [9:0]         filt_tune_o
);

  localparam int          NUM_W   = FREQ_W + 6;
  localparam int unsigned DIVISOR = (2 * XTAL_HZ) / 1000;
  localparam int          DEN_W   = $clog2(DIVISOR + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_DIV} state_t;

  state_t             state;
  logic [FREQ_W-1:0]  freq_q;
  logic [RATE_W-1:0]  rate_q;
  logic [FORCE_W-1:0] force_q;

  tword_t          att_c, gain_c, bw_c;
  logic [FT_W-1:0] ft_c;
  logic            div4_c;
  logic [1:0]      pump_c;

  tword_t          att_r, gain_r, bw_r;
  logic [FT_W-1:0] ft_r;
  logic [1:0]      pump_r;

  logic             div_load, div_busy, div_done;
  logic [NUM_W-1:0] num_c, quo;
  logic [A_W-1:0]   a_c;
  logic [N_W-1:0]   n_c;

  tuner_rate_sel #(.RATE_W(RATE_W)) u_rate (
    .rate_i (rate_q),
    .att_o  (att_c),
    .gain_o (gain_c),
    .ft_o   (ft_c)
  );

  tuner_band_sel #(.FREQ_W(FREQ_W), .FORCE_W(FORCE_W)) u_band (
    .freq_i      (freq_q),
    .force_i     (force_q),
    .band_word_o (bw_c),
    .div4_o      (div4_c),
    .pump_o      (pump_c)
  );

  assign num_c    = NUM_W'(freq_q) * (div4_c ? NUM_W'(40) : NUM_W'(20));
  assign div_load = (state == ST_SETUP);

  tuner_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .DIVISOR(DIVISOR)) u_div (
    .clk    (clk),
    .rst    (rst),
    .load_i (div_load),
    .num_i  (num_c),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (quo)
  );

  assign a_c = quo[A_W-1:0];
  assign n_c = (a_c == '0) ? quo[A_W+N_W-1:A_W] + N_W'(1) : quo[A_W+N_W-1:A_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      freq_q      <= '0;
      rate_q      <= '0;
      force_q     <= '0;
      att_r       <= '0;
      gain_r      <= '0;
      bw_r        <= '0;
      ft_r        <= '0;
      pump_r      <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      vca_word_o  <= '0;
      vga_word_o  <= '0;
      band_word_o <= '0;
      pll_word_o  <= '0;
      filt_tune_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            freq_q  <= freq_khz_i;
            rate_q  <= sym_rate_i;
            force_q <= band_force_i;
            busy_o  <= 1'b1;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          att_r  <= att_c;
          gain_r <= gain_c;
          bw_r   <= bw_c;
          ft_r   <= ft_c;
          pump_r <= pump_c;
          state  <= ST_DIV;
        end
        default: begin
          if (div_done) begin
            vca_word_o  <= att_r;
            vga_word_o  <= gain_r;
            band_word_o <= bw_r;
            filt_tune_o <= ft_r;
            pll_word_o  <= {2'b11, 2'b11, 1'b1, pump_r, n_c, a_c};
            done_o      <= 1'b1;
            busy_o      <= 1'b0;
            state       <= ST_IDLE;
          end
        end
      endcase
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && !div_busy);

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (busy_o && start_i) |=> $stable(freq_q) && $stable(rate_q) && $stable(force_q));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !done_o |-> $stable(pll_word_o) && $stable(band_word_o) && $stable(vca_word_o)
                && $stable(vga_word_o) && $stable(filt_tune_o));

  // R9
  pll_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pll_word_o[20:16] == 5'b11111);

  // R6
  pump_code_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pll_word_o[15:14] == 2'd1 || pll_word_o[15:14] == 2'd2));

  // R3
  band_shape_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $countones(band_word_o) == (band_word_o[9] ? 2 : 1));

endmodule

// File: tb/tuner_word_gen_tb.sv
`timescale 1ns/1ps
module tuner_word_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [21:0] freq = '0;
  logic [25:0] rate = '0;
  logic [3:0]  bforce = '0;
  logic        busy, done;
  logic [20:0] vca, vga, bw, pll;
  logic [9:0]  ft;

  always #4 clk = ~clk;

  tuner_word_gen u_dut (
    .clk(clk), .rst(rst), .start_i(start), .freq_khz_i(freq), .sym_rate_i(rate),
    .band_force_i(bforce), .busy_o(busy), .done_o(done), .vca_word_o(vca),
    .vga_word_o(vga), .band_word_o(bw), .pll_word_o(pll), .filt_tune_o(ft)
  );

  typedef struct packed {
    logic [20:0] vca, vga, bw, pll;
    logic [9:0]  ft;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  last_exp = '0;
  int    n_chk = 0, n_fail = 0, n_done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input longint f, input longint r, input int fb);
    exp_t e;
    longint lo[9] = '{950000, 1075000, 1178000, 1296000, 1432000,
                      1576000, 1718000, 1856000, 2036000};
    longint hi, mid, q, vco, n, a;
    int ri, b, pump;
    ri = 0;
    if (r >= 5000000 && r <= 14999999) ri = 1;
    if (r >= 15000000 && r <= 45000000) ri = 2;
    case (ri)
      1:       begin e.vca = 21'h100E1F; e.vga = 21'h0B01E0; e.ft = 10'h317; end
      2:       begin e.vca = 21'h100E3F; e.vga = 21'h0A0180; e.ft = 10'h145; end
      default: begin e.vca = 21'h100E07; e.vga = 21'h0B01E0; e.ft = 10'h27F; end
    endcase
    b = 0;
    if (fb >= 1 && fb <= 9) b = fb - 1;
    else begin
      for (int i = 0; i < 9; i++) begin
        hi = (i == 8) ? 2150000 : lo[i+1] - 1;
        if (f >= lo[i] && f <= hi) b = i;
      end
    end
    hi = (b == 8) ? 2150000 : lo[b+1] - 1;
    mid = (lo[b] + hi) / 2;
    pump = (f < mid) ? 1 : 2;
    if (b == 0)      e.bw = 21'h040;
    else if (b == 1) e.bw = 21'h080;
    else             e.bw = 21'(32'h200 | (32'h1 << (b - 2)));
    vco = (b < 2) ? 4 : 2;
    q = (f * vco * 10) / 20222;
    n = (q / 32) % 512;
    a = q % 32;
    if (a == 0) n = (n + 1) % 512;
    e.pll = 21'((32'h3 << 19) | (32'h3 << 17) | (32'h1 << 16) | (pump << 14) | (n << 5) | a);
    return e;
  endfunction

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected done", 1, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(vca == e.vca, t, "attenuator word", vca, e.vca);
        chk(vga == e.vga, t, "gain word", vga, e.vga);
        chk(ft  == e.ft,  t, "filter tune", ft, e.ft);
        chk(bw  == e.bw,  t, "band word", bw, e.bw);
        chk(pll == e.pll, t, "divider word (R9 layout)", pll, e.pll);
        last_exp = e;
      end
    end
  end

  task automatic run_vec(input int f, input int r, input int fb, input string tag);
    exp_q.push_back(model(f, r, fb));
    tag_q.push_back(tag);
    @(negedge clk);
    freq = 22'(f); rate = 26'(r); bforce = 4'(fb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(pll == 0 && bw == 0 && vca == 0, "R12", "reset words", {pll, bw}, 0);
    chk(vga == 0 && ft == 0, "R12", "reset gain/filter", {vga, ft}, 0);
    chk(busy == 0 && done == 0, "R12", "reset flags", {busy, done}, 0);

    run_vec(1000000, 2000000,  0, "R1");
    run_vec(1060000, 10000000, 0, "R6");
    run_vec(1012499, 10000000, 0, "R6");
    run_vec(1100000, 30000000, 0, "R3");
    run_vec(1500000, 45000000, 0, "R1");
    run_vec(2150000, 15000000, 0, "R3");
    run_vec(1178000, 4999999,  0, "R3");
    run_vec(1855999, 14999999, 0, "R9");
    run_vec(900000,  20000000, 0, "R4");
    run_vec(2200000, 20000000, 0, "R4");
    run_vec(2100000, 20000000, 1, "R5");
    run_vec(1000000, 20000000, 9, "R5");
    run_vec(1300000, 20000000, 12, "R5");
    run_vec(1400000, 500000,   0, "R2");
    run_vec(1700000, 50000000, 0, "R2");
    run_vec(2070733, 20000000, 0, "R8");
    run_vec(1856000, 5000000,  0, "R7");
    run_vec(1000000, 1000000,  2, "R7");

    // R11: second start during a running computation
    d0 = n_done;
    exp_q.push_back(model(1600000, 8000000, 0));
    tag_q.push_back("R11");
    @(negedge clk);
    freq = 22'd1600000; rate = 26'd8000000; bforce = 4'd0; start = 1'b1;
    @(negedge clk);
    freq = 22'd990000; rate = 26'd40000000; bforce = 4'd7;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(n_done == d0 + 1, "R11", "done count", n_done, d0 + 1);

    // R12: outputs held while idle
    chk(pll == last_exp.pll && bw == last_exp.bw && vca == last_exp.vca
        && vga == last_exp.vga && ft == last_exp.ft,
        "R12", "held divider word", pll, last_exp.pll);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule